// File: doc/BRIEF.md
# Serially Programmed Frequency-Synthesizer Loop Core

This block is the digital half of a phase-locked frequency synthesizer. A host writes a 16-bit control word through a three-wire serial port made of a data line, a shift clock and a load strobe. The word holds a 14-bit feedback divide ratio and a 2-bit prescaler code. The crystal clock is divided by a fixed ratio (6144 by default) to give the comparison rate. The VCO clock, or the VCO clock divided by two or by four, drives a programmable divide-by-N counter. Each side delivers a one-cycle comparison pulse to a phase-frequency detector, which drives up and down correction outputs to an external integrator.

The detector has three states. It rests in IDLE with both outputs low. It moves from IDLE to LEAD_REF (up high) on a reference pulse, and from IDLE to LEAD_FB (down high) on a feedback pulse. It returns from either state to IDLE as soon as the other pulse arrives, because both flops clear at once when both are set. Coincident pulses therefore leave no lasting output. The loaded prescaler code is also driven out on a port.

Top module: `synth_pll_core`

## Requirements
- R1: While reset is asserted, the outputs up_o, dn_o, ref_cmp_o, fb_cmp_o and presel_o are all zero. The control word resets to all zeros, so after release the feedback period is 2 VCO cycles.
- R2: ref_cmp_o is a single xtal_clk-cycle pulse repeating every REF_DIV (6144) xtal_clk cycles.
- R3: The serial word is shifted in MSB first, one bit on each rising ser_clk edge. Bits [15:14] form the prescaler code and bits [13:0] form the divide ratio N.
- R4: A shifted word takes effect only on the rising edge of ser_load. Until then, the previous ratio and code remain active and presel_o shows the active code.
- R5: The prescaler code sets the divisor ahead of the N counter: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /1. The fb_cmp_o period is therefore prescale × N VCO cycles.
- R6: An N value of 0 or 1 is treated as 2.
- R7: fb_cmp_o is a single vco_clk-cycle pulse.
- R8: When the feedback pulses come faster than the reference, dn_o is held high and up_o never stays high. When they come slower, up_o is held high and dn_o never stays high.
- R9: up_o and dn_o are never both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge makes the shifted word active |
| up_o | output | 1 | Detector output that asks for a higher frequency |
| dn_o | output | 1 | Detector output that asks for a lower frequency |
| ref_cmp_o | output | 1 | Divided reference comparison pulse |
| fb_cmp_o | output | 1 | Divided feedback comparison pulse |
| presel_o | output | 2 | Active prescaler code |

## Verification
The feedback divider is driven with a table of words that pairs every prescaler code with several ratios. The table includes the clamped values 0 and 1 and the full-scale ratio 16383. Each measured period separates a wrong prescale factor from a wrong N, and a wrong bit order from a wrong field split. A second word is shifted in without the strobe to show that the old period holds until the strobe rises. The detector is run with feedback much faster and then much slower than the reference, which tells apart the LEAD_FB and LEAD_REF directions and their clearing paths.

// File: rtl/synth_pll_pkg.sv
package synth_pll_pkg;
    localparam int WORD_W = 16;
    localparam int N_W    = 14;
    localparam int SEL_W  = WORD_W - N_W;

    typedef enum logic [SEL_W-1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV2  = 2'd1,
        PS_DIV4  = 2'd2,
        PS_SPARE = 2'd3
    } prescale_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [N_W-1:0]   n;
    } ctl_word_t;
endpackage

// File: rtl/synth_ser_loader.sv
module synth_ser_loader
    import synth_pll_pkg::*;
(
    input  logic      ser_clk,
    input  logic      rst_n,
    input  logic      ser_data,
    input  logic      ser_load,
    output ctl_word_t ctl
);
    logic [WORD_W-1:0] shreg;

    // MSB first: earliest bit ends in the top position after WORD_W shifts
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[WORD_W-2:0], ser_data};
    end

    always_ff @(posedge ser_load or negedge rst_n) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= ctl_word_t'(shreg);
    end
endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int REF_DIV = 6144
) (
    input  logic xtal_clk,
    input  logic rst_n,
    output logic ref_tick
);
    localparam int REF_W = $clog2(REF_DIV);
    localparam logic [REF_W-1:0] LAST = REF_W'(REF_DIV - 1);

    logic [REF_W-1:0] cnt;

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            ref_tick <= 1'b0;
        end else begin
            cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
            ref_tick <= (cnt == LAST);
        end
    end
endmodule

// File: rtl/synth_fb_path.sv
module synth_fb_path
    import synth_pll_pkg::*;
(
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_W-1:0]   n,
    output logic             fb_tick
);
    logic           q_half, q_quarter, en;
    logic [N_W-1:0] n_eff, cnt;

    // cascaded toggle stages: second stage toggles when the first is high
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            q_half    <= 1'b0;
            q_quarter <= 1'b0;
        end else begin
            q_half    <= ~q_half;
            q_quarter <= q_quarter ^ q_half;
        end
    end

    always_comb begin
        unique case (prescale_e'(sel))
            PS_DIV2: en = q_half;
            PS_DIV4: en = q_half & q_quarter;
            default: en = 1'b1;
        endcase
    end

    assign n_eff = (n < N_W'(2)) ? N_W'(2) : n;

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            fb_tick <= 1'b0;
        end else begin
            fb_tick <= en && (cnt == '0);
            if (en) cnt <= (cnt == '0) ? n_eff - 1'b1 : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
    input  logic xtal_clk,
    input  logic vco_clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up,
    output logic dn
);
    logic clr_n;

    // both set: clear both at once, so the pair returns to the idle state
    assign clr_n = rst_n & ~(up & dn);

    always_ff @(posedge xtal_clk or negedge clr_n) begin
        if (!clr_n)        up <= 1'b0;
        else if (ref_tick) up <= 1'b1;
    end

    always_ff @(posedge vco_clk or negedge clr_n) begin
        if (!clr_n)       dn <= 1'b0;
        else if (fb_tick) dn <= 1'b1;
    end
endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core
    import synth_pll_pkg::*;
#(
    parameter int REF_DIV = 6144
) (
    input  logic             xtal_clk,
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_load,
    output logic             up_o,
    output logic             dn_o,
    output logic             ref_cmp_o,
    output logic             fb_cmp_o,
    output logic [SEL_W-1:0] presel_o
);
    ctl_word_t ctl;

    synth_ser_loader u_loader (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_load (ser_load),
        .ctl      (ctl)
    );

    synth_ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .ref_tick (ref_cmp_o)
    );

    synth_fb_path u_fb (
        .vco_clk (vco_clk),
        .rst_n   (rst_n),
        .sel     (ctl.sel),
        .n       (ctl.n),
        .fb_tick (fb_cmp_o)
    );

    synth_pfd u_pfd (
        .xtal_clk (xtal_clk),
        .vco_clk  (vco_clk),
        .rst_n    (rst_n),
        .ref_tick (ref_cmp_o),
        .fb_tick  (fb_cmp_o),
        .up       (up_o),
        .dn       (dn_o)
    );

    assign presel_o = ctl.sel;
endmodule

// File: rtl/synth_pll_chk.sv
module synth_pll_chk #(
    parameter int REF_DIV = 6144
) (
    input logic xtal_clk,
    input logic vco_clk,
    input logic rst_n,
    input logic up_o,
    input logic dn_o,
    input logic ref_cmp_o,
    input logic fb_cmp_o
);
    localparam int GAP_W = $clog2(REF_DIV) + 1;

    logic [GAP_W-1:0] gap;
    logic             seen;

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (ref_cmp_o) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    p_ref_period_r2: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (ref_cmp_o && seen) |-> (gap == GAP_W'(REF_DIV)));

    p_ref_single_r2: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        ref_cmp_o |=> !ref_cmp_o);

    p_fb_single_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_cmp_o |=> !fb_cmp_o);

    p_no_overlap_r9: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        !(up_o && dn_o));

    p_up_from_ref_r8: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        $rose(up_o) |-> $past(ref_cmp_o));

    p_dn_from_fb_r8: assert property (@(posedge vco_clk) disable iff (!rst_n)
        $rose(dn_o) |-> $past(fb_cmp_o));
endmodule

bind synth_pll_core synth_pll_chk #(.REF_DIV(REF_DIV)) u_chk (
    .xtal_clk  (xtal_clk),
    .vco_clk   (vco_clk),
    .rst_n     (rst_n),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .ref_cmp_o (ref_cmp_o),
    .fb_cmp_o  (fb_cmp_o)
);

// File: tb/synth_pll_core_tb.sv
module synth_pll_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VCO_PERIOD = 4;
    localparam int SER_HALF   = 10;
    localparam int REF_DIV    = 6144;
    localparam int WDOG       = 190000;

    typedef struct packed {
        logic [1:0]  sel;
        logic [13:0] n;
        logic [31:0] per;
    } vec_t;

    // expected feedback period = prescale(sel) * max(n,2)
    localparam vec_t VECS [0:7] = '{
        '{2'd0, 14'd5,     32'd5},
        '{2'd1, 14'd5,     32'd10},
        '{2'd2, 14'd3,     32'd12},
        '{2'd3, 14'd7,     32'd7},
        '{2'd0, 14'd0,     32'd2},
        '{2'd1, 14'd1,     32'd4},
        '{2'd0, 14'd16383, 32'd16383},
        '{2'd2, 14'd2,     32'd8}
    };

    logic xtal_clk = 1'b0, vco_clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic up_o, dn_o, ref_cmp_o, fb_cmp_o;
    logic [1:0] presel_o;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    synth_pll_core #(.REF_DIV(REF_DIV)) u_dut (
        .xtal_clk  (xtal_clk),
        .vco_clk   (vco_clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_load  (ser_load),
        .up_o      (up_o),
        .dn_o      (dn_o),
        .ref_cmp_o (ref_cmp_o),
        .fb_cmp_o  (fb_cmp_o),
        .presel_o  (presel_o)
    );

    always #(CLK_PERIOD/2) xtal_clk = ~xtal_clk;
    always #(VCO_PERIOD/2) vco_clk  = ~vco_clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            ser_data = w[i];
            #SER_HALF ser_clk = 1'b1;
            #SER_HALF ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        #SER_HALF ser_load = 1'b1;
        #SER_HALF ser_load = 1'b0;
    endtask

    task automatic meas_fb(output int per);
        per = 0;
        do @(negedge vco_clk); while (fb_cmp_o !== 1'b1);
        do begin @(negedge vco_clk); per++; end while (fb_cmp_o !== 1'b1);
    endtask

    task automatic wait_ref();
        do @(negedge xtal_clk); while (ref_cmp_o !== 1'b1);
    endtask

    task automatic settle_meas(output int per);
        int tmp;
        meas_fb(tmp);
        meas_fb(tmp);
        meas_fb(per);
    endtask

    initial begin : watchdog
        for (int c = 0; c < WDOG; c++) begin
            @(posedge xtal_clk);
            if (done) disable watchdog;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=finished", WDOG);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int per, up_hi, dn_hi;
        repeat (3) @(negedge xtal_clk);
        // R1: reset state
        chk("R1 up", int'(up_o), 0);
        chk("R1 dn", int'(dn_o), 0);
        chk("R1 ref", int'(ref_cmp_o), 0);
        chk("R1 fb", int'(fb_cmp_o), 0);
        chk("R1 presel", int'(presel_o), 0);
        rst_n = 1'b1;
        settle_meas(per);
        chk("R1 default period", per, 2);

        // R2: reference rate and pulse width
        wait_ref();
        per = 0;
        do begin @(negedge xtal_clk); per++;
            if (per == 1) chk("R2 width", int'(ref_cmp_o), 0);
        end while (ref_cmp_o !== 1'b1);
        chk("R2 period", per, REF_DIV);

        // R3 R5 R6 R7: table of words
        foreach (VECS[k]) begin
            shift_word({VECS[k].sel, VECS[k].n});
            strobe();
            chk("R4 presel", int'(presel_o), int'(VECS[k].sel));
            settle_meas(per);
            chk((VECS[k].n < 2) ? "R6 clamp" : "R5 R3 period", per, int'(VECS[k].per));
            @(negedge vco_clk);
            chk("R7 width", int'(fb_cmp_o), 0);
        end

        // R4: shifted but not strobed word has no effect
        shift_word({2'd0, 14'd9});
        chk("R4 hold presel", int'(presel_o), 2);
        settle_meas(per);
        chk("R4 hold period", per, 8);
        strobe();
        settle_meas(per);
        chk("R4 new period", per, 9);
        chk("R4 new presel", int'(presel_o), 0);

        // R8: feedback much faster than reference
        shift_word({2'd0, 14'd100});
        strobe();
        wait_ref(); wait_ref();
        up_hi = 0; dn_hi = 0;
        for (int c = 0; c < 12000; c++) begin
            @(negedge xtal_clk);
            up_hi += int'(up_o);
            dn_hi += int'(dn_o);
        end
        chk("R8 fast up", up_hi, 0);
        chk("R8 fast dn held", int'(dn_hi > 6000), 1);

        // R8: feedback much slower than reference
        shift_word({2'd2, 14'd16383});
        strobe();
        wait_ref(); wait_ref();
        up_hi = 0; dn_hi = 0;
        for (int c = 0; c < 12000; c++) begin
            @(negedge xtal_clk);
            up_hi += int'(up_o);
            dn_hi += int'(dn_o);
        end
        chk("R8 slow dn", dn_hi, 0);
        chk("R8 slow up held", int'(up_hi > 6000), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule